// File: doc/BRIEF.md
# PC-relative FP literal load unit

This unit executes one floating-point literal load at a time. A caller presents a 32-bit instruction word together with the current program counter, the four condition flags and an endianness mode, and pulses `start`. The unit checks the fixed opcode bits and decodes the element size, the offset direction, the destination index and the 8-bit immediate. It then evaluates the condition, forms a byte address relative to the program counter and fetches the data over a req/ack read port. The result goes into a small internal floating-point register file.

The register file has 32 single-width slots that overlay 16 double-width registers. Single slot 2k is the low half of double k and slot 2k+1 is its high half. A read port lets the surrounding logic inspect any single slot combinationally. Illegal encodings end the operation with the `undef` flag raised together with `done`.

The control is one state machine with six states. IDLE waits for `start` and latches the operands (transition IDLE->CHECK). CHECK goes to DONE for an illegal encoding or a failed condition, and to READ0 otherwise. READ0 holds the first request until it is acknowledged, then goes to READ1 for a double load and to WRITE for the other sizes. READ1 holds the second request until it is acknowledged and then goes to WRITE. WRITE updates the register file and goes to DONE. DONE pulses `done` for one cycle and returns to IDLE.

Top module: `fplit_load_unit`

## Requirements
- R1: After reset `done`, `undef` and `mem_req` are 0 and every register slot reads 0.
- R2: The encoding is illegal in each of these cases: bits 31:28 equal 1111; bits 27:24 differ from 1101; bit 21 is 1; bit 20 is 0; bits 19:16 differ from 1111; bits 11:10 differ from 10. An illegal encoding gives `done` with `undef`=1, makes no memory request and writes no register.
- R3: The size field is bits 9:8. Size 00 is illegal. Size 01 (half) is illegal when `HALF_EN` is 0. Size 10 is single and size 11 is double. A double index at or above the number of double registers is also illegal.
- R4: The 8-bit immediate in bits 7:0 is shifted left by 1 for half and by 2 for single and double. Bit 23 set adds this offset to the base and bit 23 clear subtracts it. A subtraction of zero is legal.
- R5: The base is `pc` with its two low bits cleared. The two low bits of `pc` do not affect the address.
- R6: Bit 22 is the extra index bit. For double, bit 22 sits above bits 15:12. For half and single, bits 15:12 are the upper bits and bit 22 is the lowest bit of the single slot number.
- R7: A half load makes one request with `mem_half`=1 and takes `mem_rdata[15:0]`. It writes that value into the low 16 bits of its slot and clears the slot's upper 16 bits.
- R8: A double load reads the word at the address and then the word at the address plus 4. With `big_endian`=1 the first word becomes the high half of the result; with `big_endian`=0 it becomes the low half.
- R9: Bits 31:28 are checked against the `nzcv` flags (bit 3 N, bit 2 Z, bit 1 C, bit 0 V) using the standard table: 0000 EQ, 0001 NE, 0010 CS, 0011 CC, 0100 MI, 0101 PL, 0110 VS, 0111 VC, 1000 HI, 1001 LS, 1010 GE, 1011 LT, 1100 GT, 1101 LE, 1110 always. A failed check gives `done` with `undef`=0, makes no request and writes nothing.
- R10: A half load executes whatever its condition field and flags are, as though the check passed.
- R11: `mem_req` stays high with a stable `mem_addr` until `mem_ack`. Reads are issued in order, the register is written only after the last response, and `done` lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin executing `instr`; sampled only in IDLE |
| instr | input | 32 | Instruction word |
| pc | input | ADDR_W | Program counter value for the address base |
| nzcv | input | 4 | Condition flags N, Z, C, V (bit 3 down to bit 0) |
| big_endian | input | 1 | 1 selects big-endian merging of double words |
| mem_req | output | 1 | Read request |
| mem_addr | output | ADDR_W | Read byte address |
| mem_half | output | 1 | Request is a 16-bit access |
| mem_ack | input | 1 | Read response valid |
| mem_rdata | input | 32 | Read response data |
| done | output | 1 | One-cycle completion pulse |
| undef | output | 1 | Valid with `done`: the encoding was illegal |
| rd_slot | input | SLOT_W | Single slot to inspect |
| rd_data | output | 32 | Content of `rd_slot` |

## Verification
The bench targets the corner cases of this block. The immediate and its direction are covered at 0 with subtraction, at 255, and in both the half and word scalings; a scaling error moves the address by a factor of two. Unaligned program counters check that the base drops its low bits. Both double orderings are loaded through a slow responder, so a design that swaps the halves, reorders the reads or drops the request early returns wrong words. The half-precision condition bypass and the upper-half clearing are tested on a slot that held a nonzero value beforehand. Each illegal-bit case and each failing condition is checked for the absence of any memory request and for an unchanged slot.

// File: rtl/fplit_pkg.sv
package fplit_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_READ0,
        ST_READ1,
        ST_WRITE,
        ST_DONE
    } fsm_e;

    // encoding equals the instruction's size field
    typedef enum logic [1:0] {
        PREC_NONE   = 2'b00,
        PREC_HALF   = 2'b01,
        PREC_SINGLE = 2'b10,
        PREC_DOUBLE = 2'b11
    } prec_e;

endpackage

// File: rtl/fplit_decode.sv
module fplit_decode
    import fplit_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int NUM_DREG = 16,
    parameter bit HALF_EN  = 1'b1,
    parameter int SLOT_W   = 5
) (
    input  logic [31:0]       instr,
    output logic              illegal,
    output prec_e             prec,
    output logic              add_dir,
    output logic [3:0]        cond,
    output logic [ADDR_W-1:0] offset,
    output logic [SLOT_W-1:0] slot
);
    logic [1:0] size;
    logic [7:0] imm8;
    logic [4:0] dbl_idx;
    logic [4:0] sgl_idx;
    logic [5:0] slot_wide;
    logic       fixed_ok;
    logic       size_ok;
    logic       idx_ok;

    always_comb begin
        size    = instr[9:8];
        imm8    = instr[7:0];
        cond    = instr[31:28];
        add_dir = instr[23];
        prec    = prec_e'(size);
        dbl_idx = {instr[22], instr[15:12]};
        sgl_idx = {instr[15:12], instr[22]};

        fixed_ok = (instr[31:28] != 4'hF) && (instr[27:24] == 4'b1101) &&
                   !instr[21] && instr[20] && (instr[19:16] == 4'hF) &&
                   (instr[11:10] == 2'b10);

        unique case (size)
            2'b00:   size_ok = 1'b0;
            2'b01:   size_ok = HALF_EN;
            default: size_ok = 1'b1;
        endcase

        idx_ok = (size == 2'b11) ? (int'(dbl_idx) < NUM_DREG)
                                 : (int'(sgl_idx) < 2 * NUM_DREG);
        illegal = !(fixed_ok && size_ok && idx_ok);

        offset = (size == 2'b01) ? ADDR_W'({imm8, 1'b0}) : ADDR_W'({imm8, 2'b00});

        slot_wide = (size == 2'b11) ? {dbl_idx, 1'b0} : {1'b0, sgl_idx};
        slot      = SLOT_W'(slot_wide);
    end
endmodule

// File: rtl/fplit_cond.sv
module fplit_cond (
    input  logic [3:0] cond,
    input  logic [3:0] nzcv,
    output logic       pass
);
    logic n, z, c, v, base;

    always_comb begin
        {n, z, c, v} = nzcv;
        unique case (cond[3:1])
            3'd0:    base = z;
            3'd1:    base = c;
            3'd2:    base = n;
            3'd3:    base = v;
            3'd4:    base = c && !z;
            3'd5:    base = (n == v);
            3'd6:    base = !z && (n == v);
            default: base = 1'b1;
        endcase
        // odd codes invert the even partner; the top pair always passes
        pass = (cond[3:1] != 3'b111 && cond[0]) ? !base : base;
    end
endmodule

// File: rtl/fplit_regfile.sv
module fplit_regfile
    import fplit_pkg::*;
#(
    parameter int NUM_DREG = 16,
    parameter int SLOT_W   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  prec_e             prec,
    input  logic [SLOT_W-1:0] wslot,
    input  logic [63:0]       wdata,
    input  logic [SLOT_W-1:0] rslot,
    output logic [31:0]       rdata
);
    logic [63:0] dreg [NUM_DREG];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_DREG; i++) dreg[i] <= '0;
        end else if (we) begin
            unique case (prec)
                PREC_DOUBLE: dreg[wslot[SLOT_W-1:1]] <= wdata;
                PREC_SINGLE: begin
                    if (wslot[0]) dreg[wslot[SLOT_W-1:1]][63:32] <= wdata[31:0];
                    else          dreg[wslot[SLOT_W-1:1]][31:0]  <= wdata[31:0];
                end
                PREC_HALF: begin
                    if (wslot[0]) dreg[wslot[SLOT_W-1:1]][63:32] <= {16'h0, wdata[15:0]};
                    else          dreg[wslot[SLOT_W-1:1]][31:0]  <= {16'h0, wdata[15:0]};
                end
                default: ;
            endcase
        end
    end

    assign rdata = rslot[0] ? dreg[rslot[SLOT_W-1:1]][63:32]
                            : dreg[rslot[SLOT_W-1:1]][31:0];
endmodule

// File: rtl/fplit_load_unit.sv
module fplit_load_unit
    import fplit_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int NUM_DREG = 16,
    parameter bit HALF_EN  = 1'b1,
    localparam int SLOT_W  = $clog2(2 * NUM_DREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [31:0]       instr,
    input  logic [ADDR_W-1:0] pc,
    input  logic [3:0]        nzcv,
    input  logic              big_endian,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_half,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata,
    output logic              done,
    output logic              undef,
    input  logic [SLOT_W-1:0] rd_slot,
    output logic [31:0]       rd_data
);
    localparam logic [ADDR_W-1:0] WORD_MASK = ~ADDR_W'(3);
    localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(4);

    fsm_e              state_q, state_d;
    logic [31:0]       ir_q;
    logic [ADDR_W-1:0] pc_q;
    logic [3:0]        nzcv_q;
    logic              be_q;
    logic              undef_q;
    logic [31:0]       w0_q, w1_q;

    logic              illegal, add_dir, cond_pass, go;
    prec_e             prec;
    logic [3:0]        cond;
    logic [ADDR_W-1:0] offset, base, ea;
    logic [SLOT_W-1:0] slot;
    logic              rf_we;
    logic [63:0]       rf_wdata;

    fplit_decode #(.ADDR_W(ADDR_W), .NUM_DREG(NUM_DREG), .HALF_EN(HALF_EN), .SLOT_W(SLOT_W)) u_dec (
        .instr(ir_q), .illegal(illegal), .prec(prec), .add_dir(add_dir),
        .cond(cond), .offset(offset), .slot(slot)
    );

    fplit_cond u_cond (.cond(cond), .nzcv(nzcv_q), .pass(cond_pass));

    fplit_regfile #(.NUM_DREG(NUM_DREG), .SLOT_W(SLOT_W)) u_rf (
        .clk(clk), .rst_n(rst_n), .we(rf_we), .prec(prec), .wslot(slot),
        .wdata(rf_wdata), .rslot(rd_slot), .rdata(rd_data)
    );

    // half-precision forms run regardless of the condition outcome
    assign go   = cond_pass || (prec == PREC_HALF);
    assign base = pc_q & WORD_MASK;
    assign ea   = add_dir ? (base + offset) : (base - offset);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_CHECK;
            ST_CHECK: state_d = (illegal || !go) ? ST_DONE : ST_READ0;
            ST_READ0: if (mem_ack) state_d = (prec == PREC_DOUBLE) ? ST_READ1 : ST_WRITE;
            ST_READ1: if (mem_ack) state_d = ST_WRITE;
            ST_WRITE: state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // operand and response capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ir_q    <= '0;
            pc_q    <= '0;
            nzcv_q  <= '0;
            be_q    <= 1'b0;
            undef_q <= 1'b0;
            w0_q    <= '0;
            w1_q    <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) begin
                    ir_q    <= instr;
                    pc_q    <= pc;
                    nzcv_q  <= nzcv;
                    be_q    <= big_endian;
                    undef_q <= 1'b0;
                end
                ST_CHECK: undef_q <= illegal;
                ST_READ0: if (mem_ack) w0_q <= mem_rdata;
                ST_READ1: if (mem_ack) w1_q <= mem_rdata;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_req  = (state_q == ST_READ0) || (state_q == ST_READ1);
        mem_addr = (state_q == ST_READ1) ? (ea + WORD_STEP) : ea;
        mem_half = (prec == PREC_HALF);
        rf_we    = (state_q == ST_WRITE);
        done     = (state_q == ST_DONE);
        undef    = done && undef_q;
        if (prec == PREC_DOUBLE) rf_wdata = be_q ? {w0_q, w1_q} : {w1_q, w0_q};
        else                     rf_wdata = {32'h0, w0_q};
    end
endmodule

// File: rtl/fplit_load_chk.sv
module fplit_load_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_half,
    input logic              done,
    input logic              undef
);
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> mem_req);                                  // R11
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> $stable(mem_addr));                        // R11
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                                     // R11
    AST_UNDEF_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        undef |-> done);                                                     // R2
    AST_NO_REQ_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_req);                                                  // R9
    AST_WORD_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_half) |-> (mem_addr[1:0] == 2'b00));                // R5
    AST_HALF_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_half) |-> !mem_addr[0]);                             // R4
    AST_SECOND_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack) |=> (!mem_req || mem_addr == $past(mem_addr) + ADDR_W'(4))); // R8
endmodule

bind fplit_load_unit fplit_load_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_ack(mem_ack),
    .mem_addr(mem_addr), .mem_half(mem_half), .done(done), .undef(undef)
);

// File: tb/sim_fplit_load_unit.sv
`timescale 1ns/1ps
module sim_fplit_load_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] pc = '0;
    logic [3:0]  nzcv = '0;
    logic        big_endian = 1'b0;
    logic        mem_req, mem_half, done, undef;
    logic [31:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic [4:0]  rd_slot = '0;
    logic [31:0] rd_data;

    int checks = 0, errors = 0;
    int nreq = 0, lat = 0, wcnt = 0;
    logic req_seen = 0, half_seen = 0, got_undef = 0, finished = 0;
    logic [31:0] addr_log [2];

    always #2 clk = ~clk;

    fplit_load_unit u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .pc(pc),
        .nzcv(nzcv), .big_endian(big_endian), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_half(mem_half), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .done(done), .undef(undef),
        .rd_slot(rd_slot), .rd_data(rd_data)
    );

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return {a[15:0], ~a[15:0]};
    endfunction

    function automatic logic [31:0] enc(input logic [3:0] c, input logic u, input logic d,
                                        input logic [3:0] vd, input logic [1:0] sz,
                                        input logic [7:0] imm);
        return {c, 3'b110, 1'b1, u, d, 1'b0, 1'b1, 4'hF, vd, 2'b10, sz, imm};
    endfunction

    // responder with programmable latency
    always @(posedge clk) begin
        if (mem_req && !mem_ack) begin
            if (wcnt >= lat) begin
                mem_ack   <= 1'b1;
                mem_rdata <= mem_word(mem_addr);
                wcnt      <= 0;
            end else wcnt <= wcnt + 1;
        end else mem_ack <= 1'b0;
    end

    // request monitor
    always @(posedge clk) begin
        if (mem_req) begin
            req_seen = 1'b1;
            if (mem_half) half_seen = 1'b1;
        end
        if (mem_req && mem_ack) begin
            if (nreq < 2) addr_log[nreq] = mem_addr;
            nreq = nreq + 1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic read_slot(input logic [4:0] s, output logic [31:0] v);
        rd_slot = s;
        #1;
        v = rd_data;
    endtask

    task automatic run(input logic [31:0] ins, input logic [31:0] p,
                       input logic [3:0] f, input logic be);
        int cyc;
        @(negedge clk);
        nreq = 0; req_seen = 0; half_seen = 0;
        instr = ins; pc = p; nzcv = f; big_endian = be; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done && cyc < 200) begin
            @(negedge clk);
            cyc++;
        end
        chk("R11 done seen", {31'b0, done}, 32'd1);
        got_undef = undef;
        @(negedge clk);
        chk("R11 done one cycle", {31'b0, done}, 32'd0);
    endtask

    typedef struct packed {
        logic [3:0]  cond;
        logic        u;
        logic        d;
        logic [3:0]  vd;
        logic [1:0]  size;
        logic [7:0]  imm;
        logic [31:0] flip;
        logic [31:0] pc;
        logic [3:0]  nzcv;
        logic        be;
        logic        x_undef;
        logic [1:0]  x_nreq;
        logic [31:0] x_addr;
        logic [4:0]  slot;
        logic [31:0] x_val;
    } vec_t;

    localparam int NVEC = 12;
    localparam vec_t VEC [NVEC] = '{
        // R4 R5 R6: add, unaligned pc, single slot {Vd,D}=7
        '{4'hE, 1'b1, 1'b1, 4'h3, 2'b10, 8'h05, 32'h0, 32'h1000_0003, 4'b0000, 1'b0, 1'b0, 2'd1, 32'h1000_0014, 5'd7,  32'h0014_FFEB},
        // R4 subtract
        '{4'hE, 1'b0, 1'b0, 4'h2, 2'b10, 8'h10, 32'h0, 32'h2000_0102, 4'b0000, 1'b0, 1'b0, 2'd1, 32'h2000_00C0, 5'd4,  32'h00C0_FF3F},
        // R9 EQ fails with Z=0
        '{4'h0, 1'b1, 1'b1, 4'hA, 2'b10, 8'h00, 32'h0, 32'h4000_0000, 4'b0000, 1'b0, 1'b0, 2'd0, 32'h0,          5'd21, 32'h0},
        // R9 NE passes; R4 subtract of zero
        '{4'h1, 1'b0, 1'b0, 4'hA, 2'b10, 8'h00, 32'h0, 32'h4000_0008, 4'b0000, 1'b0, 1'b0, 2'd1, 32'h4000_0008, 5'd20, 32'h0008_FFF7},
        // R9 GT passes with N=V=1
        '{4'hC, 1'b1, 1'b1, 4'h1, 2'b10, 8'h01, 32'h0, 32'h0000_0100, 4'b1001, 1'b0, 1'b0, 2'd1, 32'h0000_0104, 5'd3,  32'h0104_FEFB},
        // R9 LT fails with N=V
        '{4'hB, 1'b1, 1'b1, 4'hA, 2'b10, 8'h00, 32'h0, 32'h4000_0000, 4'b0000, 1'b0, 1'b0, 2'd0, 32'h0,          5'd21, 32'h0},
        // R3 size 00 illegal
        '{4'hE, 1'b1, 1'b1, 4'hA, 2'b00, 8'h00, 32'h0, 32'h4000_0000, 4'b0000, 1'b0, 1'b1, 2'd0, 32'h0,          5'd21, 32'h0},
        // R2 condition 1111 illegal
        '{4'hF, 1'b1, 1'b1, 4'hA, 2'b10, 8'h00, 32'h0, 32'h4000_0000, 4'b0000, 1'b0, 1'b1, 2'd0, 32'h0,          5'd21, 32'h0},
        // R2 bit 21 set
        '{4'hE, 1'b1, 1'b1, 4'hA, 2'b10, 8'h00, 32'h0020_0000, 32'h4000_0000, 4'b0000, 1'b0, 1'b1, 2'd0, 32'h0,   5'd21, 32'h0},
        // R2 base register field not 1111
        '{4'hE, 1'b1, 1'b1, 4'hA, 2'b10, 8'h00, 32'h0001_0000, 32'h4000_0000, 4'b0000, 1'b0, 1'b1, 2'd0, 32'h0,   5'd21, 32'h0},
        // R3 R6 double index 16 out of range
        '{4'hE, 1'b1, 1'b1, 4'h0, 2'b11, 8'h00, 32'h0, 32'h4000_0000, 4'b0000, 1'b0, 1'b1, 2'd0, 32'h0,          5'd21, 32'h0},
        // R9 HI passes; R4 maximum immediate; R6 slot 30
        '{4'h8, 1'b1, 1'b0, 4'hF, 2'b10, 8'hFF, 32'h0, 32'h0000_0000, 4'b0010, 1'b0, 1'b0, 2'd1, 32'h0000_03FC, 5'd30, 32'h03FC_FC03}
    };

    initial begin
        #(4 * 100000);
        if (!finished) begin
            errors++;
            $display("FAIL R11 watchdog actual=hung expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 done", {31'b0, done}, 32'd0);
        chk("R1 undef", {31'b0, undef}, 32'd0);
        chk("R1 mem_req", {31'b0, mem_req}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        read_slot(5'd0, v);  chk("R1 slot0", v, 32'h0);
        read_slot(5'd31, v); chk("R1 slot31", v, 32'h0);

        for (int i = 0; i < NVEC; i++) begin
            run(enc(VEC[i].cond, VEC[i].u, VEC[i].d, VEC[i].vd, VEC[i].size, VEC[i].imm) ^ VEC[i].flip,
                VEC[i].pc, VEC[i].nzcv, VEC[i].be);
            chk($sformatf("R2/R3 undef vec%0d", i), {31'b0, got_undef}, {31'b0, VEC[i].x_undef});
            chk($sformatf("R9 request count vec%0d", i), nreq, {30'b0, VEC[i].x_nreq});
            if (VEC[i].x_nreq == 2'd0)
                chk($sformatf("R9 no request vec%0d", i), {31'b0, req_seen}, 32'd0);
            else
                chk($sformatf("R4/R5 address vec%0d", i), addr_log[0], VEC[i].x_addr);
            read_slot(VEC[i].slot, v);
            chk($sformatf("R6 slot value vec%0d", i), v, VEC[i].x_val);
        end

        // R7 R10: preload slot 11, then half load with a failing EQ condition
        run(enc(4'hE, 1'b1, 1'b1, 4'h5, 2'b10, 8'h03), 32'h0, 4'b0000, 1'b0);
        read_slot(5'd11, v); chk("R7 preload slot11", v, 32'h000C_FFF3);
        run(enc(4'h0, 1'b1, 1'b1, 4'h5, 2'b01, 8'hFF), 32'h3000_0001, 4'b0000, 1'b0);
        chk("R10 half executes", nreq, 32'd1);
        chk("R4 half address", addr_log[0], 32'h3000_01FE);
        chk("R7 half flag", {31'b0, half_seen}, 32'd1);
        read_slot(5'd11, v); chk("R7 half zero fill", v, 32'h0000_FE01);
        // R4 half subtract of 2
        run(enc(4'hE, 1'b0, 1'b0, 4'h0, 2'b01, 8'h01), 32'h0000_0102, 4'b0000, 1'b0);
        chk("R4 half subtract address", addr_log[0], 32'h0000_00FE);
        read_slot(5'd0, v); chk("R7 half slot0", v, 32'h0000_FF01);

        // R8 double little-endian with slow responder (R11 held request)
        lat = 3;
        run(enc(4'hE, 1'b1, 1'b0, 4'h6, 2'b11, 8'h02), 32'h5000_0000, 4'b0000, 1'b0);
        chk("R8 two reads", nreq, 32'd2);
        chk("R8 first address", addr_log[0], 32'h5000_0008);
        chk("R8 second address", addr_log[1], 32'h5000_000C);
        read_slot(5'd12, v); chk("R8 LE low half", v, 32'h0008_FFF7);
        read_slot(5'd13, v); chk("R8 LE high half", v, 32'h000C_FFF3);
        // R8 double big-endian
        lat = 1;
        run(enc(4'hE, 1'b1, 1'b0, 4'h7, 2'b11, 8'h02), 32'h5000_0002, 4'b0000, 1'b1);
        chk("R8 BE two reads", nreq, 32'd2);
        read_slot(5'd14, v); chk("R8 BE low half", v, 32'h000C_FFF3);
        read_slot(5'd15, v); chk("R8 BE high half", v, 32'h0008_FFF7);
        read_slot(5'd13, v); chk("R6 neighbour untouched", v, 32'h000C_FFF3);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule